// File: doc/BRIEF.md
# Rotating Priority Interrupt Controller

This block gathers up to eight interrupt request lines and presents one interrupt to a processor. A rising edge on a request line latches that level into a request register. A resolver picks the most urgent unmasked request that no active service level holds off, and raises `int_o`. The processor answers with two single-cycle acknowledge strobes. The first strobe marks the chosen level as in service and clears its request. The second strobe returns an 8-bit vector made of a programmable base and the level number.

Priority can change at run time. By default level 0 is the most urgent and level 7 the least. Software can name any level as the least urgent, and the remaining levels follow it in circular order. Software can also make the level that was just serviced drop to the bottom, either on an end-of-interrupt command or on the second acknowledge when automatic end-of-interrupt is on. A mode command picks which register the read port returns. The same command can turn on special mask mode, in which a masked in-service level no longer holds off other levels. It can also arm a one-shot poll read, which reports and acknowledges the best request without any acknowledge strobes.

The acknowledge, write and read paths are single-cycle strobes with no back-pressure. `vec_valid` is high for exactly one cycle, and the receiver must take `vec_o` in that cycle. A read strobe updates `rd_data` at the next clock edge, and `rd_data` then holds until the next read.

Top module: `rot_irq_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are zero and level 7 is the bottom priority, so level 0 is the most urgent. The read select points at the request register, `int_o` is low and `vec_valid` is low.
- R2: A request is latched only on a 0-to-1 transition of its `irq_in` bit. A line held high after its request has been acknowledged raises nothing new.
- R3: With the default priority order, the lowest-numbered pending level wins when several levels are pending.
- R4: A write with `wr_sel`=00 loads `wr_data` into the mask. A masked level cannot raise `int_o`, but its request stays visible in the request register.
- R5: While a level is in service, requests of equal or lower priority keep `int_o` low. A strictly higher-priority request raises `int_o`.
- R6: Acknowledge behaves as follows.
  - The first `inta` strobe sets the in-service bit of the winning level, clears its request bit and drops `int_o`.
  - The second strobe makes `vec_valid` high for one cycle with `vec_o` = {base[4:0], level[2:0]}.
  - If nothing was eligible at the first strobe, the level field reads 7 and no in-service bit is set.
- R7: Priority commands are writes with `wr_sel`=01, with fields R=bit7, SL=bit6, EOI=bit5 and L=bits2:0. R=0,SL=0,EOI=1 clears the highest-priority in-service bit. R=0,SL=1,EOI=1 clears in-service bit L.
- R8: R=1,SL=0,EOI=1 clears the highest-priority in-service bit, and that level becomes the bottom priority.
- R9: R=1,SL=1,EOI=0 makes level L the bottom priority, so level L+1 (mod 8) is the most urgent. R=1,SL=1,EOI=1 does this and also clears in-service bit L.
- R10: A write with `wr_sel`=11 loads base from bits 7:3 and sets automatic end-of-interrupt from bit 0. With automatic end-of-interrupt on, the in-service bit clears at the second strobe. R=1,SL=0,EOI=0 turns on auto-rotation, which then also makes the acknowledged level the bottom priority at the second strobe. R=0,SL=0,EOI=0 turns auto-rotation off.
- R11: A write with `wr_sel`=10 is a mode command. Its bits 1:0 select what a read returns: 01 the mask, 10 the request register, 11 the in-service register, and 00 leaves the selection unchanged. Read data appears on `rd_data` one cycle after `rd_en`.
- R12: In a mode command, bit 6=1 loads special mask mode from bit 5. In special mask mode, an in-service level that is also masked no longer holds off lower levels.
- R13: A mode command with bit 2=1 arms one poll read. The next read returns {pending, 0000, level} and acknowledges that level as the first strobe would, then the poll mode disarms. An empty poll returns 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Request lines, edge sensitive |
| inta | input | 1 | Acknowledge strobe, one cycle per pulse |
| wr_en | input | 1 | Command write strobe |
| wr_sel | input | 2 | Write target: 00 mask, 01 priority command, 10 mode command, 11 config |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| int_o | output | 1 | Interrupt to processor |
| vec_valid | output | 1 | One-cycle qualifier for `vec_o` |
| vec_o | output | 8 | Interrupt vector |

## Verification
The bench builds the block with its default parameters: three level bits, which give eight levels, and an 8-bit data path. These defaults make every circular priority order reachable, including wrap-around from level 7 to level 0. The bench programs a base of 10101b so that the upper vector bits differ from reset. It then moves the bottom level to 1, 3, 0 and 5, which shows that the winner follows the rotated order and not the level number. Nested service, special mask mode, automatic end-of-interrupt with rotation, and poll reads are each driven into states where a fixed-priority design would give a different vector or `int_o` value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'b00,
    SEL_PRIO = 2'b01,
    SEL_MODE = 2'b10,
    SEL_CFG  = 2'b11
  } wr_sel_e;

  typedef enum logic {
    ACK_IDLE   = 1'b0,
    ACK_SECOND = 1'b1
  } ack_st_e;

  localparam logic [1:0] RSEL_KEEP = 2'b00;
  localparam logic [1:0] RSEL_MASK = 2'b01;
  localparam logic [1:0] RSEL_REQ  = 2'b10;
  localparam logic [1:0] RSEL_SRV  = 2'b11;
endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int LVL_W = 3,
  localparam int N_LVL = 1 << LVL_W
) (
  input  logic [N_LVL-1:0] req,
  input  logic [LVL_W-1:0] bottom,
  output logic             hit,
  output logic [LVL_W-1:0] lvl
);
  // Walk the levels in circular order, starting just above the bottom level.
  always_comb begin
    logic [LVL_W-1:0] idx;
    hit = 1'b0;
    lvl = '0;
    idx = '0;
    for (int k = 0; k < N_LVL; k++) begin
      idx = bottom + LVL_W'(1) + LVL_W'(k);
      if (!hit && req[idx]) begin
        hit = 1'b1;
        lvl = idx;
      end
    end
  end
endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int N_LVL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] irq_in,
  input  logic [N_LVL-1:0] clr,
  output logic [N_LVL-1:0] irr
);
  logic [N_LVL-1:0] irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq_in;
      irr   <= (irr & ~clr) | (irq_in & ~irq_q);
    end
  end
endmodule

// File: rtl/rot_irq_ctrl.sv
module rot_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int DAT_W = 8,
  localparam int N_LVL = 1 << LVL_W,
  localparam int BASE_W = DAT_W - LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] irq_in,
  input  logic             inta,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [DAT_W-1:0] rd_data,
  output logic             int_o,
  output logic             vec_valid,
  output logic [DAT_W-1:0] vec_o
);
  // State
  logic [N_LVL-1:0]  irr, mask_q, isr_q;
  logic [LVL_W-1:0]  bottom_q, cur_lvl;
  logic [BASE_W-1:0] base_q;
  logic              aeoi_q, arot_q, smm_q, poll_q, spur_q;
  logic [1:0]        rsel_q;
  ack_st_e           state_q;

  // Resolution
  logic [N_LVL-1:0] isr_eff;
  logic             r_hit, b_hit, e_hit;
  logic [LVL_W-1:0] r_lvl, b_lvl, e_lvl, r_rank, b_rank;
  logic             elig, ack2nd;

  assign isr_eff = smm_q ? (isr_q & ~mask_q) : isr_q;

  irqc_prio_pick #(.LVL_W(LVL_W)) u_pick_req (
    .req(irr & ~mask_q), .bottom(bottom_q), .hit(r_hit), .lvl(r_lvl));
  irqc_prio_pick #(.LVL_W(LVL_W)) u_pick_blk (
    .req(isr_eff), .bottom(bottom_q), .hit(b_hit), .lvl(b_lvl));
  irqc_prio_pick #(.LVL_W(LVL_W)) u_pick_eoi (
    .req(isr_q), .bottom(bottom_q), .hit(e_hit), .lvl(e_lvl));

  assign r_rank = r_lvl - bottom_q - LVL_W'(1);
  assign b_rank = b_lvl - bottom_q - LVL_W'(1);
  assign elig   = r_hit && (!b_hit || (r_rank < b_rank));
  assign ack2nd = (state_q == ACK_SECOND);
  assign int_o  = elig && !ack2nd;

  // Command decode and set/clear vectors
  logic             cmd_prio, cmd_mode, cmd_cfg, cmd_mask;
  logic             c_r, c_sl, c_eoi;
  logic [LVL_W-1:0] c_l;
  logic             ack1, ack2, poll_rd;
  logic [N_LVL-1:0] isr_set, isr_clr, irr_clr;
  logic [LVL_W-1:0] bot_n;

  assign cmd_mask = wr_en && (wr_sel == SEL_MASK);
  assign cmd_prio = wr_en && (wr_sel == SEL_PRIO);
  assign cmd_mode = wr_en && (wr_sel == SEL_MODE);
  assign cmd_cfg  = wr_en && (wr_sel == SEL_CFG);
  assign c_r      = wr_data[DAT_W-1];
  assign c_sl     = wr_data[DAT_W-2];
  assign c_eoi    = wr_data[DAT_W-3];
  assign c_l      = wr_data[LVL_W-1:0];
  assign ack1     = inta && !ack2nd;
  assign ack2     = inta && ack2nd;
  assign poll_rd  = rd_en && poll_q && !ack2nd;

  always_comb begin
    isr_set = '0;
    isr_clr = '0;
    irr_clr = '0;
    bot_n   = bottom_q;
    if (cmd_prio) begin
      unique case ({c_r, c_sl, c_eoi})
        3'b001: if (e_hit) isr_clr[e_lvl] = 1'b1;
        3'b101: if (e_hit) begin
          isr_clr[e_lvl] = 1'b1;
          bot_n          = e_lvl;
        end
        3'b011: isr_clr[c_l] = 1'b1;
        3'b111: begin
          isr_clr[c_l] = 1'b1;
          bot_n        = c_l;
        end
        3'b110: bot_n = c_l;
        default: ;
      endcase
    end
    if ((ack1 || poll_rd) && elig) begin
      isr_set[r_lvl] = 1'b1;
      irr_clr[r_lvl] = 1'b1;
    end
    if (ack2 && aeoi_q && !spur_q) begin
      isr_clr[cur_lvl] = 1'b1;
      if (arot_q) bot_n = cur_lvl;
    end
  end

  irqc_req_latch #(.N_LVL(N_LVL)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(irr_clr), .irr(irr));

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      isr_q    <= '0;
      bottom_q <= '1;
      base_q   <= '0;
      aeoi_q   <= 1'b0;
      arot_q   <= 1'b0;
      smm_q    <= 1'b0;
      poll_q   <= 1'b0;
      rsel_q   <= RSEL_REQ;
    end else begin
      isr_q    <= (isr_q & ~isr_clr) | isr_set;
      bottom_q <= bot_n;
      if (cmd_mask) mask_q <= wr_data[N_LVL-1:0];
      if (cmd_cfg) begin
        base_q <= wr_data[DAT_W-1:LVL_W];
        aeoi_q <= wr_data[0];
      end
      if (cmd_prio && !c_sl && !c_eoi) arot_q <= c_r;
      if (poll_rd) poll_q <= 1'b0;
      if (cmd_mode) begin
        if (wr_data[6]) smm_q <= wr_data[5];
        if (wr_data[2]) poll_q <= 1'b1;
        if (wr_data[1:0] != RSEL_KEEP) rsel_q <= wr_data[1:0];
      end
    end
  end

  // Acknowledge sequence and vector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ACK_IDLE;
      cur_lvl   <= '0;
      spur_q    <= 1'b0;
      vec_valid <= 1'b0;
      vec_o     <= '0;
    end else begin
      vec_valid <= 1'b0;
      if (ack1) begin
        state_q <= ACK_SECOND;
        cur_lvl <= elig ? r_lvl : '1;
        spur_q  <= !elig;
      end else if (ack2) begin
        state_q   <= ACK_IDLE;
        vec_valid <= 1'b1;
        vec_o     <= {base_q, cur_lvl};
      end
    end
  end

  // Read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (poll_rd) begin
        rd_data <= {elig, (DAT_W-1-LVL_W)'(0), elig ? r_lvl : LVL_W'(0)};
      end else begin
        unique case (rsel_q)
          RSEL_MASK: rd_data <= DAT_W'(mask_q);
          RSEL_SRV:  rd_data <= DAT_W'(isr_q);
          default:   rd_data <= DAT_W'(irr);
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
  parameter int LVL_W = 3,
  parameter int DAT_W = 8,
  localparam int N_LVL = 1 << LVL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inta,
  input logic             wr_en,
  input logic             int_o,
  input logic             vec_valid,
  input logic [DAT_W-1:0] vec_o,
  input logic [N_LVL-1:0] irr,
  input logic [N_LVL-1:0] isr_q,
  input logic [N_LVL-1:0] mask_q,
  input logic             smm_q,
  input logic             aeoi_q,
  input logic             ack2nd,
  input logic             spur_q,
  input logic [LVL_W-1:0] cur_lvl,
  input logic [LVL_W-1:0] r_lvl,
  input logic [DAT_W-LVL_W-1:0] base_q
);
  assert_int_has_unmasked_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr & ~mask_q) != '0));

  assert_winner_not_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> !(isr_q[r_lvl] && !(smm_q && mask_q[r_lvl])));

  assert_first_ack_adds_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_o && !wr_en) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  assert_vector_follows_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(ack2nd && inta) && (vec_o[DAT_W-1:LVL_W] == base_q)));

  assert_auto_eoi_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack2nd && inta && aeoi_q && !spur_q && !wr_en) |=> !isr_q[$past(cur_lvl)]);
endmodule

bind rot_irq_ctrl irqc_checks #(.LVL_W(LVL_W), .DAT_W(DAT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .inta(inta), .wr_en(wr_en), .int_o(int_o),
  .vec_valid(vec_valid), .vec_o(vec_o), .irr(irr), .isr_q(isr_q),
  .mask_q(mask_q), .smm_q(smm_q), .aeoi_q(aeoi_q), .ack2nd(ack2nd),
  .spur_q(spur_q), .cur_lvl(cur_lvl), .r_lvl(r_lvl), .base_q(base_q));

// File: tb/tb_rot_irq_ctrl.sv
module tb_rot_irq_ctrl;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       inta = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data, vec_o;
  logic       int_o, vec_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  rot_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .inta(inta), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .int_o(int_o), .vec_valid(vec_valid), .vec_o(vec_o));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] exp);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic raise(logic [7:0] bits);
    irq_in = irq_in | bits;
    step();
  endtask

  task automatic drop_all();
    irq_in = '0;
    step();
  endtask

  task automatic ack(string tag, logic [7:0] exp_vec);
    inta = 1'b1;
    step();
    chk({tag, " int low after first strobe (R6)"}, {7'd0, int_o}, 8'd0);
    step();
    inta = 1'b0;
    chk({tag, " vec_valid (R6)"}, {7'd0, vec_valid}, 8'd1);
    chk({tag, " vector"}, vec_o, exp_vec);
    step();
    chk({tag, " vec_valid one cycle (R6)"}, {7'd0, vec_valid}, 8'd0);
  endtask

  task automatic t_reset();
    chk("R1 int_o", {7'd0, int_o}, 8'd0);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
    rd("R1 request reg read", 8'h00);
    wr(2'b10, 8'h03);
    rd("R1 in-service reg read", 8'h00);
    wr(2'b10, 8'h01);
    rd("R1 mask read", 8'h00);
    wr(2'b10, 8'h02);
  endtask

  task automatic t_fixed();
    wr(2'b11, 8'hA8);
    raise(8'h28);
    chk("R3 int with two pending", {7'd0, int_o}, 8'd1);
    ack("R3 level 3 wins", 8'hAB);
    chk("R5 lower level held off", {7'd0, int_o}, 8'd0);
    wr(2'b10, 8'h03);
    rd("R6 service bit 3", 8'h08);
    wr(2'b10, 8'h02);
    rd("R6 request 3 cleared", 8'h20);
    wr(2'b01, 8'h20);
    chk("R7 EOI releases level 5", {7'd0, int_o}, 8'd1);
    ack("R3 level 5 next", 8'hAD);
    wr(2'b01, 8'h20);
    chk("R2 held lines no new request", {7'd0, int_o}, 8'd0);
    drop_all();
  endtask

  task automatic t_nest();
    raise(8'h20);
    ack("R5 serve 5", 8'hAD);
    raise(8'h40);
    chk("R5 level 6 held off", {7'd0, int_o}, 8'd0);
    raise(8'h04);
    chk("R5 level 2 preempts", {7'd0, int_o}, 8'd1);
    ack("R5 serve 2", 8'hAA);
    wr(2'b01, 8'h20);
    wr(2'b10, 8'h03);
    rd("R7 non-specific clears level 2", 8'h20);
    chk("R5 6 still held by 5", {7'd0, int_o}, 8'd0);
    wr(2'b01, 8'h65);
    rd("R7 specific clears level 5", 8'h00);
    chk("R7 level 6 now raises", {7'd0, int_o}, 8'd1);
    ack("R5 serve 6", 8'hAE);
    wr(2'b01, 8'h20);
    wr(2'b10, 8'h02);
    drop_all();
  endtask

  task automatic t_mask();
    wr(2'b00, 8'h10);
    raise(8'h10);
    chk("R4 masked level quiet", {7'd0, int_o}, 8'd0);
    rd("R4 masked request visible", 8'h10);
    wr(2'b10, 8'h01);
    rd("R11 mask read", 8'h10);
    wr(2'b00, 8'hC3);
    rd("R11 mask read second value", 8'hC3);
    wr(2'b00, 8'h00);
    wr(2'b10, 8'h02);
    chk("R4 unmasked raises", {7'd0, int_o}, 8'd1);
    ack("R4 serve 4", 8'hAC);
    wr(2'b01, 8'h20);
    drop_all();
  endtask

  task automatic t_rotate_eoi();
    raise(8'h02);
    ack("R8 serve 1", 8'hA9);
    wr(2'b01, 8'hA0);
    raise(8'h09);
    ack("R8 level 3 beats 0 after rotation", 8'hAB);
    wr(2'b01, 8'hA0);
    ack("R8 level 0 last", 8'hA8);
    wr(2'b01, 8'hA0);
    drop_all();
    wr(2'b01, 8'hC7);
  endtask

  task automatic t_setprio();
    wr(2'b01, 8'hC5);
    raise(8'h50);
    ack("R9 bottom 5 makes 6 win", 8'hAE);
    chk("R9 level 4 below 6", {7'd0, int_o}, 8'd0);
    wr(2'b01, 8'h20);
    ack("R9 then 4", 8'hAC);
    wr(2'b01, 8'h20);
    drop_all();
    wr(2'b01, 8'hC7);
  endtask

  task automatic t_aeoi();
    wr(2'b11, 8'hA9);
    wr(2'b01, 8'h80);
    raise(8'h03);
    ack("R10 serve 0", 8'hA8);
    wr(2'b10, 8'h03);
    rd("R10 service cleared automatically", 8'h00);
    ack("R10 serve 1", 8'hA9);
    drop_all();
    raise(8'h81);
    ack("R10 rotated: 7 beats 0", 8'hAF);
    ack("R10 then 0", 8'hA8);
    rd("R10 no service left", 8'h00);
    wr(2'b10, 8'h02);
    wr(2'b11, 8'hA8);
    wr(2'b01, 8'h00);
    drop_all();
    wr(2'b01, 8'hC7);
  endtask

  task automatic t_smm();
    raise(8'h08);
    ack("R12 serve 3", 8'hAB);
    wr(2'b00, 8'h08);
    raise(8'h20);
    chk("R12 normal mode holds off 5", {7'd0, int_o}, 8'd0);
    wr(2'b10, 8'h60);
    chk("R12 special mask releases 5", {7'd0, int_o}, 8'd1);
    ack("R12 serve 5", 8'hAD);
    wr(2'b01, 8'h65);
    wr(2'b01, 8'h63);
    wr(2'b10, 8'h40);
    wr(2'b00, 8'h00);
    drop_all();
  endtask

  task automatic t_poll();
    raise(8'h50);
    wr(2'b10, 8'h04);
    rd("R13 poll reports 4", 8'h84);
    wr(2'b10, 8'h03);
    rd("R13 poll acknowledged 4", 8'h10);
    wr(2'b01, 8'h20);
    wr(2'b10, 8'h04);
    rd("R13 poll reports 6", 8'h86);
    wr(2'b01, 8'h20);
    wr(2'b10, 8'h04);
    rd("R13 empty poll", 8'h00);
    wr(2'b10, 8'h02);
    drop_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_nest();
    t_mask();
    t_rotate_eoi();
    t_setprio();
    t_aeoi();
    t_smm();
    t_poll();
    finish_run();
  end
endmodule